// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block produces the fetch address for an in-order RISC pipeline. In that pipeline a branch or jump has an architectural delay slot, so the instruction or instructions placed after the branch in program order always execute, whether or not the branch is taken. The parameter `NSLOT` selects one slot or two. The execute stage reports each branch through a resolve strobe, a taken flag and a signed offset. That report arrives in the same cycle the branch sits at `fetch_pc`. The block computes the target as the branch's own address plus 4 plus the sign-extended offset, and it fetches that target only after the last delay slot.

For the instruction currently issuing, the block records whether it sits in a delay slot and at which position. When an interrupt is accepted on a slot instruction, the block rewinds the saved restart address to the owning branch, so the branch runs again on return. A branch that resolves inside another branch's slot breaks that rewind rule, and the block reports it on an error pin. There is no data stream at this block's edge. `stall` is the only back-pressure: while it is high, every piece of state holds, and a resolve report or an interrupt request presented in that cycle is not taken.

Top module: `dslot_pc_seq`

## Requirements
- R1: On reset `fetch_pc` equals `RESET_PC`, `issue_in_slot` and `epc_was_slot` are 0, `epc` is 0, and no redirect is pending.
- R2: With no branch report and no interrupt, each unstalled cycle advances `fetch_pc` by 4.
- R3: With `NSLOT`=1, a taken report at address P with offset O makes the next fetch P+4, flagged `issue_in_slot`=1, and the fetch after it P+4+O with the flag cleared.
- R4: With `NSLOT`=2, a taken report at P makes the next two fetches P+4 and P+8, both flagged in-slot, and then P+4+O.
- R5: A not-taken report still marks the following instruction as a slot, and sequential fetch continues at P+8 with no extra bubble.
- R6: While `stall`=1, `fetch_pc`, the slot flag and any pending redirect hold. A resolve report or interrupt request in that cycle is ignored, and `irq_accept` stays 0.
- R7: `irq_accept` is 1 in any unstalled cycle with `irq_req`=1. After that edge `fetch_pc`=`VECTOR_PC`. For an instruction outside a slot, `epc` becomes its own address and `epc_was_slot` becomes 0.
- R8: An interrupt accepted on a slot instruction at position k (1 = first slot) sets `epc` to its address minus 4·k and `epc_was_slot` to 1. It also discards the pending redirect, so fetch continues at `VECTOR_PC`+4.
- R9: `nest_err` is 1 in an unstalled, non-interrupted cycle that carries a resolve report while `issue_in_slot`=1, and 0 for a report outside a slot.
- R10: A taken branch that resolves inside an earlier branch's slot keeps the earlier redirect. Its own redirect follows its own slot count, so with `NSLOT`=1 the fetch order is B1, B2, T1, T2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Holds all state for the cycle |
| br_valid | input | 1 | A branch or jump at `fetch_pc` resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| br_offset | input | OFFW | Signed byte offset, added to branch address + 4 |
| irq_req | input | 1 | Interrupt request |
| fetch_pc | output | 32 | Address of the instruction issuing now |
| issue_in_slot | output | 1 | The issuing instruction occupies a delay slot |
| nest_err | output | 1 | A branch resolved inside a delay slot |
| irq_accept | output | 1 | Interrupt taken this cycle; vector fetched next |
| epc | output | 32 | Restart address saved on the last accepted interrupt |
| epc_was_slot | output | 1 | `epc` was rewound to the owning branch |

## Verification
`irq_accept` and `nest_err` are combinational, so the bench reads them after the inputs settle and before the rising edge. `fetch_pc`, `issue_in_slot`, `epc` and `epc_was_slot` change one edge after their stimulus, so they are read a nanosecond after that edge. A taken target is expected `NSLOT`+1 edges after its report, and each of those edges is stepped and checked individually. Expected addresses come from arithmetic on the address the bench saw at the start of each scenario, not from the design's internal state.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  localparam int unsigned PC_W = 32;
  typedef logic [PC_W-1:0] pc_t;

  // one scheduled redirect: due when it reaches the head of the queue
  typedef struct packed {
    logic due;
    pc_t  tgt;
  } redir_t;
endpackage

// File: rtl/dslot_redir_q.sv
module dslot_redir_q
  import dslot_pkg::*;
#(
  parameter int unsigned NSLOT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic flush,
  input  logic push,
  input  pc_t  push_tgt,
  output logic head_due,
  output pc_t  head_tgt
);
  // entry k becomes the head after k more unstalled cycles
  redir_t q [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_ent
    if (k == NSLOT - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n || flush) q[k] <= '0;
        else if (adv)        q[k] <= '{due: push, tgt: push_tgt};
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n || flush) q[k] <= '0;
        else if (adv)        q[k] <= q[k+1];
      end
    end
  end

  assign head_due = q[0].due;
  assign head_tgt = q[0].tgt;
endmodule

// File: rtl/dslot_slot_trk.sv
module dslot_slot_trk #(
  parameter int unsigned NSLOT = 1,
  localparam int unsigned POSW = $clog2(NSLOT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            flush,
  input  logic            br,
  output logic            in_slot,
  output logic [POSW-1:0] pos,
  output logic            nest
);
  logic [POSW-1:0] pos_q;

  // position of the issuing instruction after its latest branch; 0 = none
  always_ff @(posedge clk) begin
    if (!rst_n || flush) pos_q <= '0;
    else if (adv) begin
      if (br)                                       pos_q <= POSW'(1);
      else if (pos_q != '0 && pos_q < POSW'(NSLOT)) pos_q <= pos_q + POSW'(1);
      else                                          pos_q <= '0;
    end
  end

  assign pos     = pos_q;
  assign in_slot = (pos_q != '0);
  assign nest    = adv && br && in_slot;
endmodule

// File: rtl/dslot_epc.sv
module dslot_epc
  import dslot_pkg::*;
#(
  parameter int unsigned POSW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            in_slot,
  input  logic [POSW-1:0] pos,
  input  pc_t             pc,
  output pc_t             epc,
  output logic            was_slot
);
  pc_t rewind;
  assign rewind = PC_W'(pos) << 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc      <= '0;
      was_slot <= 1'b0;
    end else if (accept) begin
      epc      <= in_slot ? pc - rewind : pc;
      was_slot <= in_slot;
    end
  end
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import dslot_pkg::*;
#(
  parameter int unsigned NSLOT     = 1,
  parameter int unsigned OFFW      = 16,
  parameter logic [31:0] RESET_PC  = 32'hBFC0_0000,
  parameter logic [31:0] VECTOR_PC = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            br_valid,
  input  logic            br_taken,
  input  logic [OFFW-1:0] br_offset,
  input  logic            irq_req,
  output logic [31:0]     fetch_pc,
  output logic            issue_in_slot,
  output logic            nest_err,
  output logic            irq_accept,
  output logic [31:0]     epc,
  output logic            epc_was_slot
);
  localparam int unsigned POSW = $clog2(NSLOT + 1);

  pc_t             pc_q, br_tgt, head_tgt;
  logic            adv, accept, head_due;
  logic [POSW-1:0] pos;

  assign accept = !stall && irq_req;
  assign adv    = !stall && !irq_req;
  assign br_tgt = pc_q + PC_W'(4) + {{(PC_W-OFFW){br_offset[OFFW-1]}}, br_offset};

  dslot_redir_q #(.NSLOT(NSLOT)) redir_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(accept),
    .push(br_valid && br_taken), .push_tgt(br_tgt),
    .head_due(head_due), .head_tgt(head_tgt)
  );

  dslot_slot_trk #(.NSLOT(NSLOT)) slot_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .flush(accept), .br(br_valid),
    .in_slot(issue_in_slot), .pos(pos), .nest(nest_err)
  );

  dslot_epc #(.POSW(POSW)) epc_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_slot(issue_in_slot),
    .pos(pos), .pc(pc_q), .epc(epc), .was_slot(epc_was_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= RESET_PC;
    else if (accept) pc_q <= VECTOR_PC;
    else if (adv)    pc_q <= head_due ? head_tgt : pc_q + PC_W'(4);
  end

  assign fetch_pc   = pc_q;
  assign irq_accept = accept;
endmodule

// File: rtl/dslot_pc_seq_chk.sv
module dslot_pc_seq_chk #(
  parameter logic [31:0] VECTOR_PC = 32'h0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        br_valid,
  input logic        irq_req,
  input logic [31:0] fetch_pc,
  input logic        issue_in_slot,
  input logic        nest_err,
  input logic        irq_accept,
  input logic        epc_was_slot
);
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !irq_req && !issue_in_slot) |=> fetch_pc == $past(fetch_pc) + 32'd4);

  assert_slot_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !stall && !irq_req) |=> issue_in_slot);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_pc) && $stable(issue_in_slot)));

  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> fetch_pc == VECTOR_PC);

  assert_rewind_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && issue_in_slot) |=> epc_was_slot);

  assert_nest_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err |-> (issue_in_slot && br_valid));
endmodule

bind dslot_pc_seq dslot_pc_seq_chk #(.VECTOR_PC(VECTOR_PC)) chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_valid(br_valid),
  .irq_req(irq_req), .fetch_pc(fetch_pc), .issue_in_slot(issue_in_slot),
  .nest_err(nest_err), .irq_accept(irq_accept), .epc_was_slot(epc_was_slot)
);

// File: tb/dslot_pc_seq_tb_top.sv
`timescale 1ns/1ps
module dslot_pc_seq_tb_top;
  localparam logic [31:0] RP  = 32'h0000_1000;
  localparam logic [31:0] VEC = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic a_stall = 0, a_brv = 0, a_tk = 0, a_irq = 0;
  logic [15:0] a_off = '0;
  logic [31:0] a_pc, a_epc;
  logic a_slot, a_nest, a_acc, a_ws;

  logic b_stall = 0, b_brv = 0, b_tk = 0, b_irq = 0;
  logic [15:0] b_off = '0;
  logic [31:0] b_pc, b_epc;
  logic b_slot, b_nest, b_acc, b_ws;

  dslot_pc_seq #(.NSLOT(1), .RESET_PC(RP), .VECTOR_PC(VEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall(a_stall), .br_valid(a_brv), .br_taken(a_tk),
    .br_offset(a_off), .irq_req(a_irq), .fetch_pc(a_pc), .issue_in_slot(a_slot),
    .nest_err(a_nest), .irq_accept(a_acc), .epc(a_epc), .epc_was_slot(a_ws));

  dslot_pc_seq #(.NSLOT(2), .RESET_PC(RP), .VECTOR_PC(VEC)) dut2_i (
    .clk(clk), .rst_n(rst_n), .stall(b_stall), .br_valid(b_brv), .br_taken(b_tk),
    .br_offset(b_off), .irq_req(b_irq), .fetch_pc(b_pc), .issue_in_slot(b_slot),
    .nest_err(b_nest), .irq_accept(b_acc), .epc(b_epc), .epc_was_slot(b_ws));

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive single-slot inputs now (away from the edge); they settle within 1 ns
  task automatic drv_a(input logic s, input logic bv, input logic tk,
                       input logic [15:0] off, input logic irq);
    a_stall = s; a_brv = bv; a_tk = tk; a_off = off; a_irq = irq;
    #1;
  endtask

  task automatic drv_b(input logic s, input logic bv, input logic tk,
                       input logic [15:0] off, input logic irq);
    b_stall = s; b_brv = bv; b_tk = tk; b_off = off; b_irq = irq;
    #1;
  endtask

  // pass one rising edge, then clear all stimulus
  task automatic edge_step();
    @(posedge clk);
    #1;
    a_stall = 0; a_brv = 0; a_tk = 0; a_off = '0; a_irq = 0;
    b_stall = 0; b_brv = 0; b_tk = 0; b_off = '0; b_irq = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 pc", a_pc, RP);
    check("R1 slot", {31'b0, a_slot}, 32'd0);
    check("R1 epc", a_epc, 32'd0);
    check("R1 was_slot", {31'b0, a_ws}, 32'd0);
    check("R1 pc dual", b_pc, RP);
    edge_step();
    check("R1 no pending redirect", a_pc, RP + 4);
    check("R1 no slot after reset", {31'b0, a_slot}, 32'd0);
  endtask

  task automatic t_sequential();
    logic [31:0] p;
    p = a_pc;
    for (int i = 1; i <= 3; i++) begin
      edge_step();
      check("R2 sequential", a_pc, p + 32'(4 * i));
    end
  endtask

  task automatic t_taken_single();
    logic [31:0] p;
    p = a_pc;
    drv_a(0, 1, 1, 16'h0100, 0);
    check("R9 no error outside slot", {31'b0, a_nest}, 32'd0);
    edge_step();
    check("R3 slot pc", a_pc, p + 4);
    check("R3 slot flag", {31'b0, a_slot}, 32'd1);
    edge_step();
    check("R3 target", a_pc, p + 4 + 32'h100);
    check("R3 flag clear", {31'b0, a_slot}, 32'd0);
  endtask

  task automatic t_backward();
    logic [31:0] p;
    p = a_pc;
    drv_a(0, 1, 1, 16'hFFF0, 0);
    edge_step();
    edge_step();
    check("R3 negative offset", a_pc, p + 4 - 32'h10);
  endtask

  task automatic t_not_taken();
    logic [31:0] p;
    p = a_pc;
    drv_a(0, 1, 0, 16'h0200, 0);
    edge_step();
    check("R5 slot pc", a_pc, p + 4);
    check("R5 slot flag", {31'b0, a_slot}, 32'd1);
    edge_step();
    check("R5 no bubble", a_pc, p + 8);
    check("R5 flag clear", {31'b0, a_slot}, 32'd0);
  endtask

  task automatic t_stall();
    logic [31:0] p;
    p = a_pc;
    drv_a(0, 1, 1, 16'h0040, 0);
    edge_step();
    drv_a(1, 1, 1, 16'h0400, 1);
    check("R6 no accept under stall", {31'b0, a_acc}, 32'd0);
    check("R6 no error under stall", {31'b0, a_nest}, 32'd0);
    edge_step();
    check("R6 pc held", a_pc, p + 4);
    check("R6 slot held", {31'b0, a_slot}, 32'd1);
    edge_step();
    check("R6 redirect kept", a_pc, p + 4 + 32'h40);
    check("R6 ignored report left no slot", {31'b0, a_slot}, 32'd0);
    edge_step();
    check("R6 ignored report left no redirect", a_pc, p + 4 + 32'h40 + 4);
  endtask

  task automatic t_irq_plain();
    logic [31:0] p;
    p = a_pc;
    drv_a(0, 0, 0, '0, 1);
    check("R7 accept", {31'b0, a_acc}, 32'd1);
    edge_step();
    check("R7 vector", a_pc, VEC);
    check("R7 epc", a_epc, p);
    check("R7 was_slot", {31'b0, a_ws}, 32'd0);
  endtask

  task automatic t_irq_slot_single();
    logic [31:0] p;
    p = a_pc;
    drv_a(0, 1, 1, 16'h0300, 0);
    edge_step();
    drv_a(0, 0, 0, '0, 1);
    edge_step();
    check("R8 vector", a_pc, VEC);
    check("R8 epc rewound", a_epc, p);
    check("R8 was_slot", {31'b0, a_ws}, 32'd1);
    edge_step();
    check("R8 redirect discarded", a_pc, VEC + 4);
  endtask

  task automatic t_nested();
    logic [31:0] p, t1;
    p = a_pc;
    t1 = p + 4 + 32'h200;
    drv_a(0, 1, 1, 16'h0200, 0);
    edge_step();
    drv_a(0, 1, 1, 16'h0300, 0);
    check("R9 nested error", {31'b0, a_nest}, 32'd1);
    edge_step();
    check("R10 first target", a_pc, t1);
    check("R10 first target is slot", {31'b0, a_slot}, 32'd1);
    edge_step();
    check("R10 second target", a_pc, p + 4 + 4 + 32'h300);
    check("R10 slot clear", {31'b0, a_slot}, 32'd0);
  endtask

  task automatic t_double();
    logic [31:0] p;
    p = b_pc;
    drv_b(0, 1, 1, 16'h0040, 0);
    edge_step();
    check("R4 first slot", b_pc, p + 4);
    check("R4 first slot flag", {31'b0, b_slot}, 32'd1);
    edge_step();
    check("R4 second slot", b_pc, p + 8);
    check("R4 second slot flag", {31'b0, b_slot}, 32'd1);
    edge_step();
    check("R4 target", b_pc, p + 4 + 32'h40);
    check("R4 flag clear", {31'b0, b_slot}, 32'd0);
  endtask

  task automatic t_irq_slot_double();
    logic [31:0] q;
    q = b_pc;
    drv_b(0, 1, 1, 16'h0080, 0);
    edge_step();
    edge_step();
    drv_b(0, 0, 0, '0, 1);
    check("R7 accept dual", {31'b0, b_acc}, 32'd1);
    edge_step();
    check("R8 second-slot epc", b_epc, q);
    check("R8 second-slot was_slot", {31'b0, b_ws}, 32'd1);
    check("R8 dual vector", b_pc, VEC);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sequential();
    t_taken_single();
    t_backward();
    t_not_taken();
    t_stall();
    t_irq_plain();
    t_irq_slot_single();
    t_nested();
    t_double();
    t_irq_slot_double();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule